// File: doc/BRIEF.md
# Shared Serial Line Access Arbiter

This block gives one station controlled transmit access to a serial line that it shares with other stations. The line is open-drain: any station that drives '0' pulls it low, and it rests at '1' when nobody is sending. Each station reads the resolved line back on a feedback input. The arbiter counts consecutive '1' bits on that input to decide when the line is free. It starts a pending frame only when enough quiet bits have passed. While it sends, it checks every bit it drives against the bit it reads back.

On any disagreement the station has lost the line. It stops driving data, returns to '1', reports a collision and keeps the frame for a later retry. A station that has just finished a frame must wait two extra quiet bits before it may send again. Its competitors can therefore get in first, which rotates priority among the stations.

Frames are loaded as a parallel word with a last-bit index. Bit 0 goes out first. Bit timing comes from a clock-enable that marks each bit period.

Top module: `sbus_arbiter`

## Requirements
- R1: `bus_idle` is 1 only when at least IDLE_BITS (default 8) consecutive '1' bits have been sampled on `line_rx`, counting only cycles with `bit_en` = 1. After exactly 7 such bits following a '0' it is still 0, and after the 8th it is 1.
- R2: A '0' sampled on `line_rx` in a `bit_en` cycle clears the quiet count, so `bus_idle` is 0 in the next cycle.
- R3: In every `bit_en` cycle while `tx_active` = 1, the block compares `line_tx` with `line_rx`. A mismatch in either direction gives a collision, reported as `coll_pulse` = 1 for exactly one cycle in the following cycle.
- R4: In the cycle where `coll_pulse` = 1, `line_tx` = 1, `tx_active` = 0 and the frame is still held (`frm_ready` = 0).
- R5: While `tx_active` = 0 (nothing pending, or the line is busy), `line_tx` stays at 1.
- R6: After the last bit of a frame passes its comparison, `done_pulse` = 1 for one cycle. In that cycle `line_tx` = 1, `tx_active` = 0 and `frm_ready` = 1 again, and quiet counting restarts from zero.
- R7: A pending frame starts only in a `bit_en` cycle in which the quiet count has already reached its threshold. After a collision the threshold is IDLE_BITS, so with `bit_en` high every cycle and a quiet line, `tx_active` rises 9 cycles after `coll_pulse`.
- R8: After a successful frame, the threshold for the next start is BACKOFF_BITS (default 10). With `bit_en` high every cycle and a quiet line, `tx_active` rises 11 cycles after `done_pulse`.
- R9: After a collision the held frame is retried automatically from bit 0, and the full frame is sent on the retry.
- R10: The quiet count saturates at BACKOFF_BITS and never wraps, so `bus_idle` stays 1 through any run of '1' bits.
- R11: Synchronous active-high `rst` gives `line_tx` = 1, `tx_active` = 0, `bus_idle` = 0, `frm_ready` = 1, and clears all counters.
- R12: A frame is taken when `frm_valid` and `frm_ready` are both 1 at a clock edge. `frm_last` is the bit count minus one. Bits go out in order from `frm_data[0]`, one per `bit_en` period, and `line_tx` changes only in `bit_en` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-period enable; the line is sampled and advanced on these cycles |
| line_rx | input | 1 | Resolved line read back (feedback) |
| line_tx | output | 1 | Driven bit; 1 when not sending |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Buffer empty, frame can be taken |
| frm_data | input | MAX_BITS | Frame bits, bit 0 sent first |
| frm_last | input | LEN_W | Index of the last bit (length minus one) |
| bus_idle | output | 1 | Quiet count has reached IDLE_BITS |
| tx_active | output | 1 | Frame bits are being driven |
| coll_pulse | output | 1 | One-cycle collision report |
| done_pulse | output | 1 | One-cycle successful-completion report |

## Verification
On every cycle the assertions check these invariants:
- `line_tx` rests at 1 whenever the block is not sending.
- A collision or completion pulse always coincides with release of the line.
- A collision pulse always follows an actual mismatch in a `bit_en` cycle.
- A start only happens on an enabled cycle with the threshold met.
- A sampled '0' always clears `bus_idle`.
- The quiet count stays within its saturation limit.

The exact quiet-bit counts, and the difference between the 9-cycle and 11-cycle restart delays, can only be shown by the bench's timed scenarios. The same holds for bit-order integrity of a retried frame and for collisions in both directions. The random phase compares every output against a bench model while other stations talk over the line.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic {ST_WAIT, ST_SEND} tx_state_e;

  // A collision is any disagreement between the driven and the resolved bit.
  function automatic logic bit_clash(input logic sent, input logic seen);
    return sent ^ seen;
  endfunction
endpackage

// File: rtl/sba_idle_mon.sv
module sba_idle_mon #(
  parameter int IDLE_BITS    = 8,
  parameter int BACKOFF_BITS = 10,
  parameter int CNT_W        = $clog2(BACKOFF_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             line_rx,
  input  logic             clr,
  input  logic             own_last,
  output logic [CNT_W-1:0] cnt,
  output logic             bus_idle,
  output logic             start_ok
);
  localparam logic [CNT_W-1:0] IDLE_THR = CNT_W'(IDLE_BITS);
  localparam logic [CNT_W-1:0] BACK_THR = CNT_W'(BACKOFF_BITS);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v >= BACK_THR) ? BACK_THR : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (bit_en) begin
      if (!line_rx)       cnt <= '0;
      else                cnt <= sat_inc(cnt);
    end
  end

  assign bus_idle = (cnt >= IDLE_THR);
  assign start_ok = (cnt >= (own_last ? BACK_THR : IDLE_THR));
endmodule

// File: rtl/sba_frame_buf.sv
module sba_frame_buf #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_valid,
  input  logic [MAX_BITS-1:0] frm_data,
  input  logic [LEN_W-1:0]    frm_last,
  input  logic                release_frm,
  input  logic [LEN_W-1:0]    sel_idx,
  output logic                frm_ready,
  output logic                held,
  output logic                cur_bit,
  output logic [LEN_W-1:0]    last_idx
);
  logic [MAX_BITS-1:0] data_q;

  assign frm_ready = !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      data_q   <= '0;
      last_idx <= '0;
    end else if (release_frm) begin
      held <= 1'b0;
    end else if (frm_valid && !held) begin
      held     <= 1'b1;
      data_q   <= frm_data;
      last_idx <= frm_last;
    end
  end

  assign cur_bit = data_q[sel_idx];
endmodule

// File: rtl/sba_tx_ctrl.sv
module sba_tx_ctrl
  import sba_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             line_rx,
  input  logic             held,
  input  logic             start_ok,
  input  logic             cur_bit,
  input  logic [LEN_W-1:0] last_idx,
  output logic [LEN_W-1:0] sel_idx,
  output logic             line_tx,
  output logic             tx_active,
  output logic             coll_pulse,
  output logic             done_pulse,
  output logic             own_last,
  output logic             finish_now,
  output logic             clash_now
);
  tx_state_e        state;
  logic [LEN_W-1:0] idx;
  logic             launch_now;

  assign tx_active  = (state == ST_SEND);
  assign clash_now  = tx_active && bit_en && bit_clash(line_tx, line_rx);
  assign finish_now = tx_active && bit_en && !clash_now && (idx == last_idx);
  assign launch_now = !tx_active && bit_en && held && start_ok;
  assign sel_idx    = tx_active ? idx + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      idx        <= '0;
      line_tx    <= 1'b1;
      coll_pulse <= 1'b0;
      done_pulse <= 1'b0;
      own_last   <= 1'b0;
    end else begin
      coll_pulse <= clash_now;
      done_pulse <= finish_now;
      if (launch_now) begin
        state    <= ST_SEND;
        idx      <= '0;
        line_tx  <= cur_bit;
        own_last <= 1'b0;
      end else if (clash_now) begin
        state   <= ST_WAIT;
        line_tx <= 1'b1;
      end else if (finish_now) begin
        state    <= ST_WAIT;
        line_tx  <= 1'b1;
        own_last <= 1'b1;
      end else if (tx_active && bit_en) begin
        idx     <= idx + 1'b1;
        line_tx <= cur_bit;
      end
    end
  end
endmodule

// File: rtl/sbus_arbiter.sv
module sbus_arbiter #(
  parameter int MAX_BITS     = 32,
  parameter int IDLE_BITS    = 8,
  parameter int BACKOFF_BITS = 10,
  parameter int LEN_W        = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                line_rx,
  output logic                line_tx,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [MAX_BITS-1:0] frm_data,
  input  logic [LEN_W-1:0]    frm_last,
  output logic                bus_idle,
  output logic                tx_active,
  output logic                coll_pulse,
  output logic                done_pulse
);
  localparam int CNT_W = $clog2(BACKOFF_BITS + 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             start_ok;
  logic             own_last;
  logic             finish_now;
  logic             clash_now;
  logic             held;
  logic             cur_bit;
  logic [LEN_W-1:0] last_idx;
  logic [LEN_W-1:0] sel_idx;

  sba_idle_mon #(
    .IDLE_BITS(IDLE_BITS), .BACKOFF_BITS(BACKOFF_BITS), .CNT_W(CNT_W)
  ) u_idle (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_rx(line_rx),
    .clr(finish_now), .own_last(own_last),
    .cnt(idle_cnt), .bus_idle(bus_idle), .start_ok(start_ok)
  );

  sba_frame_buf #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_last(frm_last), .release_frm(finish_now), .sel_idx(sel_idx),
    .frm_ready(frm_ready), .held(held), .cur_bit(cur_bit), .last_idx(last_idx)
  );

  sba_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_rx(line_rx),
    .held(held), .start_ok(start_ok), .cur_bit(cur_bit), .last_idx(last_idx),
    .sel_idx(sel_idx), .line_tx(line_tx), .tx_active(tx_active),
    .coll_pulse(coll_pulse), .done_pulse(done_pulse), .own_last(own_last),
    .finish_now(finish_now), .clash_now(clash_now)
  );
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int BACKOFF_BITS = 10,
  parameter int CNT_W        = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             line_rx,
  input logic             line_tx,
  input logic             tx_active,
  input logic             coll_pulse,
  input logic             done_pulse,
  input logic             bus_idle,
  input logic             start_ok,
  input logic [CNT_W-1:0] idle_cnt
);
  AST_BUSY_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !line_rx) |=> !bus_idle); // R2
  AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    coll_pulse |-> $past(bit_en && tx_active && (line_tx != line_rx))); // R3
  AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    coll_pulse |-> (line_tx && !tx_active)); // R4
  AST_COLL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    coll_pulse |=> !coll_pulse); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> line_tx); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (line_tx && !tx_active && (idle_cnt == '0))); // R6
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> $past(bit_en && start_ok)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= CNT_W'(BACKOFF_BITS)); // R10
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && tx_active) |=> $stable(line_tx)); // R12
endmodule

bind sbus_arbiter sba_checker #(.BACKOFF_BITS(BACKOFF_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .line_rx(line_rx), .line_tx(line_tx),
  .tx_active(tx_active), .coll_pulse(coll_pulse), .done_pulse(done_pulse),
  .bus_idle(bus_idle), .start_ok(start_ok), .idle_cnt(idle_cnt)
);

// File: tb/tb_sbus_arbiter.sv
`timescale 1ns/1ps
module tb_sbus_arbiter;
  localparam int MAXB = 32;
  localparam int LW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b1;
  logic line_rx, line_tx, frm_valid, frm_ready, bus_idle, tx_active, coll_pulse, done_pulse;
  logic [MAXB-1:0] frm_data;
  logic [LW-1:0]   frm_last;

  logic en_all = 1'b1;
  int   other_mode = 0;
  logic other_bit = 1'b1;
  logic force_en = 1'b0, force_val = 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  logic [MAXB-1:0] cap;
  int cap_n = 0;

  always #5 clk = ~clk;

  assign line_rx = force_en ? force_val : (line_tx & other_bit);

  sbus_arbiter dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_rx(line_rx), .line_tx(line_tx),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data), .frm_last(frm_last),
    .bus_idle(bus_idle), .tx_active(tx_active), .coll_pulse(coll_pulse), .done_pulse(done_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bit_en <= en_all ? 1'b1 : ($urandom % 3 == 0);
    other_bit <= (other_mode == 1) ? ($urandom % 6 != 0) : (other_mode == 2) ? 1'b0 : 1'b1;
  end

  // ---- bench reference model (bit-period view) ----
  function automatic int thr(input bit own);
    return own ? 10 : 8;
  endfunction

  bit m_tx = 1, m_send = 0, m_own = 0, m_held = 0, m_coll = 0, m_done = 0;
  int m_cnt = 0, m_idx = 0, m_last = 0;
  logic [MAXB-1:0] m_data = '0;

  always @(posedge clk) begin
    bit rx, fin, go;
    if (rst) begin
      m_tx = 1; m_send = 0; m_own = 0; m_held = 0; m_coll = 0; m_done = 0; m_cnt = 0; m_idx = 0;
    end else begin
      rx  = force_en ? force_val : (m_tx & other_bit);
      fin = 0;
      go  = (m_cnt >= thr(m_own));
      m_coll = 0; m_done = 0;
      if (m_send && bit_en) begin
        if (m_tx != rx) begin m_coll = 1; m_tx = 1; m_send = 0; end
        else if (m_idx == m_last) begin m_done = 1; m_tx = 1; m_send = 0; m_own = 1; fin = 1; end
        else begin m_idx++; m_tx = m_data[m_idx]; end
      end else if (!m_send && bit_en && m_held && go) begin
        m_send = 1; m_idx = 0; m_tx = m_data[0]; m_own = 0;
      end
      if (fin) m_cnt = 0;
      else if (bit_en) m_cnt = rx ? ((m_cnt + 1 > 10) ? 10 : m_cnt + 1) : 0;
      if (fin) m_held = 0;
      else if (frm_valid && !m_held) begin m_held = 1; m_data = frm_data; m_last = int'(frm_last); end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(line_tx == m_tx, "R5", "model line_tx", line_tx, m_tx);
      chk(tx_active == m_send, "R7", "model tx_active", tx_active, m_send);
      chk(coll_pulse == m_coll, "R3", "model coll_pulse", coll_pulse, m_coll);
      chk(done_pulse == m_done, "R6", "model done_pulse", done_pulse, m_done);
      chk(bus_idle == (m_cnt >= 8), "R1", "model bus_idle", bus_idle, m_cnt >= 8);
      chk(frm_ready == !m_held, "R12", "model frm_ready", frm_ready, !m_held);
      if (bit_en && tx_active && cap_n < MAXB) begin cap[cap_n] = line_tx; cap_n++; end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic ticks(input int n);
    repeat (n) begin
      while (!bit_en) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [MAXB-1:0] d, input int last);
    while (!frm_ready) @(negedge clk);
    frm_valid = 1'b1; frm_data = d; frm_last = LW'(last);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // which: 0 tx_active, 1 done_pulse, 2 coll_pulse, 3 frm_ready
  task automatic wait_for(input int which, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      if ((which == 0 && tx_active) || (which == 1 && done_pulse) ||
          (which == 2 && coll_pulse) || (which == 3 && frm_ready)) begin hit = 1; break; end
      @(negedge clk);
    end
  endtask

  function automatic bit same_bits(input logic [MAXB-1:0] a, input logic [MAXB-1:0] b, input int last);
    for (int i = 0; i <= last; i++) if (a[i] !== b[i]) return 0;
    return 1;
  endfunction

  initial begin
    bit hit;
    int t0, t1;
    logic [MAXB-1:0] f1, f2, f3;
    void'($urandom(32'd9157));
    frm_valid = 0; frm_data = '0; frm_last = '0;
    repeat (3) @(negedge clk);
    chk(line_tx == 1, "R11", "reset line_tx", line_tx, 1);
    chk(bus_idle == 0, "R11", "reset bus_idle", bus_idle, 0);
    chk(tx_active == 0, "R11", "reset tx_active", tx_active, 0);
    chk(frm_ready == 1, "R11", "reset frm_ready", frm_ready, 1);
    rst = 1'b0;

    ticks(7);
    chk(bus_idle == 0, "R1", "idle after 7 ones", bus_idle, 0);
    ticks(1);
    chk(bus_idle == 1, "R1", "idle after 8 ones", bus_idle, 1);

    force_en = 1; force_val = 0;
    ticks(1);
    chk(bus_idle == 0, "R2", "busy after zero", bus_idle, 0);

    f1 = 32'h0000_0A5C;
    cap_n = 0;
    send_frame(f1, 11);
    for (int i = 0; i < 20; i++) begin
      chk(line_tx == 1 && tx_active == 0, "R5", "quiet while line held low", line_tx, 1);
      @(negedge clk);
    end
    force_en = 0;
    wait_for(1, 200, hit);
    chk(hit, "R6", "done seen", hit, 1);
    t0 = cyc;
    chk(frm_ready == 1, "R6", "buffer freed at done", frm_ready, 1);
    chk(cap_n == 12 && same_bits(cap, f1, 11), "R12", "sent bits", int'(cap[11:0]), int'(f1[11:0]));

    f2 = 32'h0000_3C71;
    send_frame(f2, 13);
    wait_for(0, 200, hit);
    t1 = cyc;
    chk(t1 - t0 == 11, "R8", "own restart delay", t1 - t0, 11);
    force_en = 1; force_val = 0;
    @(negedge clk);
    force_en = 0;
    chk(coll_pulse == 1, "R3", "collision 1 sent 0 seen", coll_pulse, 1);
    chk(line_tx == 1 && tx_active == 0, "R4", "released after collision", line_tx, 1);
    chk(frm_ready == 0, "R4", "frame kept after collision", frm_ready, 0);
    t0 = cyc; cap_n = 0;
    wait_for(0, 200, hit);
    chk(cyc - t0 == 9, "R7", "restart delay after collision", cyc - t0, 9);
    wait_for(1, 200, hit);
    chk(hit && cap_n == 14 && same_bits(cap, f2, 13), "R9", "retry from bit 0", int'(cap[13:0]), int'(f2[13:0]));

    f3 = 32'h0000_00F6;
    send_frame(f3, 7);
    wait_for(0, 200, hit);
    chk(line_tx == 0, "R12", "first bit from frm_data[0]", line_tx, 0);
    force_en = 1; force_val = 1;
    @(negedge clk);
    force_en = 0;
    chk(coll_pulse == 1, "R3", "collision 0 sent 1 seen", coll_pulse, 1);
    wait_for(1, 300, hit);
    chk(hit, "R9", "frame finishes after retry", hit, 1);

    ticks(40);
    chk(bus_idle == 1, "R10", "no wrap on long quiet", bus_idle, 1);

    en_all = 0;
    for (int k = 0; k < 30; k++) begin
      send_frame($urandom, $urandom % MAXB);
      for (int w = 0; w < 200 && !frm_ready; w++) begin
        other_mode = ($urandom % 3 == 0) ? 1 : 0;
        repeat (25) @(negedge clk);
      end
    end
    other_mode = 0;
    wait_for(3, 5000, hit);
    chk(hit, "R9", "random frames all delivered", hit, 1);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule